// File: doc/BRIEF.md
# Status and Interrupt Mask Controller

This block keeps a 24-bit status word and a 24-bit interrupt mask. Both are reached through a small register port with a 5-bit address, separate write and read strobes and 24-bit data. Single-cycle event pulses from neighbouring logic set status bits. Software clears a bit by writing a one to it, so it can write back a word it has read and clear only the bits it has seen. An active-low interrupt output goes low while any status bit that counts as active has its mask bit set.

Two bits behave differently from the rest. Bit 0 is a command-health flag with inverted sense. It reads one in normal operation, drops to zero on a command-error pulse, ignores every bus write and returns to one only on an interface re-initialisation pulse. Bit 5 belongs to a watchdog that counts clock cycles since the last read of a watched data register. The watchdog is a three-state machine:

- `WD_RUN` counts cycles and restarts on each data read. On reaching the timeout it moves to `WD_FIRED` and sets bit 5.
- `WD_FIRED` holds the count. A data read moves it to `WD_ARMED`.
- `WD_ARMED` accepts a write of one to bit 5. That clears the bit and returns the machine to `WD_RUN` with a zero count.

Top module: `status_intr_ctrl`

## Requirements
- R1: The status word is at address 0x0F and the mask at address 0x1A. A read strobe updates the read data one clock later with the addressed contents. Any other address reads as zero.
- R2: After reset the status word is 0x000001, the mask is 0x000000 and the interrupt output is high.
- R3: Writing a one to a status bit (other than bits 0 and 5) clears it. Writing a zero leaves the bit unchanged.
- R4: An event pulse on `evt_i[i]` sets status bit i whatever the mask holds. Event lines 0 and 5 have no effect.
- R5: `irq_n_o` is low exactly when some bit is both active and unmasked. Bit 0 counts as active when it is zero, and every other bit counts as active when it is one.
- R6: When an event and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set.
- R7: A pulse on `cmd_err_i` drives bit 0 to zero. Writes to the status word never change bit 0. A pulse on `if_init_i` returns it to one. If both pulses arrive in the same cycle, the error wins.
- R8: Bit 5 sets once `WD_TIMEOUT` clock edges have passed with no pulse on `data_rd_i`. Each data read restarts the count.
- R9: A write of one to bit 5 clears it only if a data read has occurred since the bit was set. Without that read, the bit stays set.
- R10: Writes to any address other than 0x0F and 0x1A change neither register.
- R11: A write to the mask address stores all 24 data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | 5 | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 24 | Write data |
| rdata_o | output | 24 | Read data, valid one cycle after the read strobe |
| evt_i | input | 24 | Per-bit event pulses |
| cmd_err_i | input | 1 | Command-error pulse that drives bit 0 low |
| if_init_i | input | 1 | Interface re-initialisation pulse that drives bit 0 high |
| data_rd_i | input | 1 | Pulse marking a read of the watched data register |
| irq_n_o | output | 1 | Active-low interrupt |

## Verification
The bench drives an event and a clearing write onto the same bit in one cycle. A design that let the clear win would lose an event that software never saw.

It writes ones to bit 0 and tries to clear bit 5 with no data read first. A plain write-one-to-clear design would wrongly drop the command-health flag or acknowledge a watchdog trip that was never handled.

It times the watchdog edge by edge from a data read and restarts the count mid-window. An off-by-one counter or a missing restart shows up as the interrupt moving one cycle early or late.

Writes to unused addresses and events on masked bits are checked through read-back and the interrupt pin. Leaky address decoding, or mask gating applied to the status bits themselves, shows up there.

// File: rtl/sic_pkg.sv
package sic_pkg;
    localparam int          DW         = 24;
    localparam int          AW         = 5;
    localparam logic [4:0]  ADDR_STAT  = 5'h0F;
    localparam logic [4:0]  ADDR_MASK  = 5'h1A;
    localparam int          BIT_CMD_OK = 0;
    localparam int          BIT_WDOG   = 5;
    localparam logic [23:0] STAT_RST   = 24'h000001;
    localparam logic [23:0] MASK_RST   = 24'h000000;
    localparam logic [23:0] PLAIN_BITS = ~((24'd1 << BIT_CMD_OK) | (24'd1 << BIT_WDOG));

    typedef enum logic [1:0] {
        WD_RUN   = 2'd0,
        WD_FIRED = 2'd1,
        WD_ARMED = 2'd2
    } wd_state_e;
endpackage

// File: rtl/sic_watchdog.sv
module sic_watchdog
    import sic_pkg::*;
#(
    parameter int WD_TIMEOUT = 20_480_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic data_rd_i,
    input  logic wr_wd_one_i,
    output logic wd_set_o,
    output logic wd_clr_ok_o
);
    localparam int CW = $clog2(WD_TIMEOUT + 1);
    localparam logic [CW-1:0] LAST = CW'(WD_TIMEOUT - 1);

    wd_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            WD_RUN: begin
                if (data_rd_i) begin
                    cnt_d = '0;
                end else if (cnt_q == LAST) begin
                    cnt_d   = '0;
                    state_d = WD_FIRED;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            WD_FIRED: begin
                if (data_rd_i) state_d = WD_ARMED;
            end
            WD_ARMED: begin
                if (wr_wd_one_i) begin
                    state_d = WD_RUN;
                    cnt_d   = '0;
                end
            end
            default: state_d = WD_RUN;
        endcase
    end

    always_comb begin
        wd_set_o    = (state_q == WD_RUN) && !data_rd_i && (cnt_q == LAST);
        wd_clr_ok_o = (state_q == WD_ARMED);
    end
endmodule

// File: rtl/sic_status_bank.sv
module sic_status_bank
    import sic_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stat_i,
    input  logic          wr_mask_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [DW-1:0] evt_i,
    input  logic          cmd_err_i,
    input  logic          if_init_i,
    input  logic          wd_set_i,
    input  logic          wd_clr_ok_i,
    output logic [DW-1:0] status_o,
    output logic [DW-1:0] mask_o
);
    logic [DW-1:0] stat_q;
    logic [DW-1:0] mask_q;

    for (genvar i = 0; i < DW; i++) begin : g_bit
        if (i == BIT_CMD_OK) begin : g_cmd
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)         stat_q[i] <= STAT_RST[i];
                else if (cmd_err_i) stat_q[i] <= 1'b0;
                else if (if_init_i) stat_q[i] <= 1'b1;
            end
        end else if (i == BIT_WDOG) begin : g_wd
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                                    stat_q[i] <= STAT_RST[i];
                else if (wd_set_i)                             stat_q[i] <= 1'b1;
                else if (wr_stat_i && wdata_i[i] && wd_clr_ok_i) stat_q[i] <= 1'b0;
            end
        end else begin : g_plain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                       stat_q[i] <= STAT_RST[i];
                else if (evt_i[i])                stat_q[i] <= 1'b1;
                else if (wr_stat_i && wdata_i[i]) stat_q[i] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         mask_q <= MASK_RST;
        else if (wr_mask_i) mask_q <= wdata_i;
    end

    assign status_o = stat_q;
    assign mask_o   = mask_q;
endmodule

// File: rtl/sic_readback.sv
module sic_readback
    import sic_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] status_i,
    input  logic [DW-1:0] mask_i,
    output logic [DW-1:0] rdata_o
);
    logic [DW-1:0] sel;

    always_comb begin
        unique case (addr_i)
            ADDR_STAT: sel = status_i;
            ADDR_MASK: sel = mask_i;
            default:   sel = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    rdata_o <= '0;
        else if (rd_i) rdata_o <= sel;
    end
endmodule

// File: rtl/status_intr_ctrl.sv
module status_intr_ctrl
    import sic_pkg::*;
#(
    parameter int WD_TIMEOUT = 20_480_000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_i,
    input  logic          wr_i,
    input  logic          rd_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    input  logic [DW-1:0] evt_i,
    input  logic          cmd_err_i,
    input  logic          if_init_i,
    input  logic          data_rd_i,
    output logic          irq_n_o
);
    logic          wr_stat, wr_mask;
    logic          wd_set, wd_clr_ok;
    logic [DW-1:0] status, mask;
    logic [DW-1:0] active;

    assign wr_stat = wr_i && (addr_i == ADDR_STAT);
    assign wr_mask = wr_i && (addr_i == ADDR_MASK);

    sic_watchdog #(.WD_TIMEOUT(WD_TIMEOUT)) u_wd (
        .clk         (clk),
        .rst_n       (rst_n),
        .data_rd_i   (data_rd_i),
        .wr_wd_one_i (wr_stat && wdata_i[BIT_WDOG]),
        .wd_set_o    (wd_set),
        .wd_clr_ok_o (wd_clr_ok)
    );

    sic_status_bank u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_stat_i   (wr_stat),
        .wr_mask_i   (wr_mask),
        .wdata_i     (wdata_i),
        .evt_i       (evt_i),
        .cmd_err_i   (cmd_err_i),
        .if_init_i   (if_init_i),
        .wd_set_i    (wd_set),
        .wd_clr_ok_i (wd_clr_ok),
        .status_o    (status),
        .mask_o      (mask)
    );

    sic_readback u_rb (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_i     (rd_i),
        .addr_i   (addr_i),
        .status_i (status),
        .mask_i   (mask),
        .rdata_o  (rdata_o)
    );

    assign active  = status ^ (DW'(1) << BIT_CMD_OK);
    assign irq_n_o = ~|(active & mask);
endmodule

// File: rtl/status_intr_ctrl_sva.sv
module status_intr_ctrl_sva
    import sic_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] addr_i,
    input logic          wr_i,
    input logic [DW-1:0] wdata_i,
    input logic [DW-1:0] evt_i,
    input logic          cmd_err_i,
    input logic          if_init_i,
    input logic [DW-1:0] status,
    input logic [DW-1:0] mask,
    input logic          wd_clr_ok,
    input logic          irq_n_o
);
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == ADDR_STAT) |=>
        ((status & $past(wdata_i & ~evt_i & PLAIN_BITS)) == '0)); // R3

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_i & PLAIN_BITS)) |=>
        ((status & $past(evt_i & PLAIN_BITS)) == $past(evt_i & PLAIN_BITS))); // R4

    AST_NO_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> irq_n_o); // R5

    AST_CMD_OK_WRITE_PROOF: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !cmd_err_i && !if_init_i) |=> $stable(status[BIT_CMD_OK])); // R7

    AST_WD_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (status[BIT_WDOG] && !wd_clr_ok) |=> status[BIT_WDOG]); // R9

    AST_OTHER_ADDR_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i != ADDR_MASK) |=> $stable(mask)); // R10
endmodule

bind status_intr_ctrl status_intr_ctrl_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_i    (addr_i),
    .wr_i      (wr_i),
    .wdata_i   (wdata_i),
    .evt_i     (evt_i),
    .cmd_err_i (cmd_err_i),
    .if_init_i (if_init_i),
    .status    (status),
    .mask      (mask),
    .wd_clr_ok (wd_clr_ok),
    .irq_n_o   (irq_n_o)
);

// File: tb/sim_status_intr_ctrl.sv
`timescale 1ns/1ps
module sim_status_intr_ctrl;
    localparam int          T    = 300;
    localparam logic [23:0] WDM  = 24'h000020;
    localparam logic [4:0]  A_ST = 5'h0F;
    localparam logic [4:0]  A_MK = 5'h1A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  addr_i = '0;
    logic        wr_i = 1'b0, rd_i = 1'b0;
    logic [23:0] wdata_i = '0, rdata_o, evt_i = '0;
    logic        cmd_err_i = 1'b0, if_init_i = 1'b0, data_rd_i = 1'b0;
    logic        irq_n_o;
    int          n_run = 0, n_fail = 0;
    logic [23:0] rv;

    always #4 clk = ~clk;

    status_intr_ctrl #(.WD_TIMEOUT(T)) u0 (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .evt_i(evt_i), .cmd_err_i(cmd_err_i),
        .if_init_i(if_init_i), .data_rd_i(data_rd_i), .irq_n_o(irq_n_o)
    );

    task automatic chk(input string req, input logic [23:0] got, input logic [23:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %06h expected %06h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [23:0] d);
        addr_i = a; wdata_i = d; wr_i = 1'b1;
        @(negedge clk);
        wr_i = 1'b0; wdata_i = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [23:0] d);
        addr_i = a; rd_i = 1'b1;
        @(negedge clk);
        rd_i = 1'b0;
        d = rdata_o;
    endtask

    task automatic ev(input logic [23:0] e);
        evt_i = e;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic t_reset();
        rd(A_ST, rv); chk("R2 status reset", rv, 24'h000001);
        rd(A_MK, rv); chk("R2 mask reset", rv, 24'h000000);
        chk("R2 irq idle", {23'd0, irq_n_o}, 24'd1);
    endtask

    task automatic t_mask_rw();
        wr(A_MK, 24'hABCDE0);
        rd(A_MK, rv); chk("R11 mask stores all bits", rv, 24'hABCDE0);
        rd(5'h03, rv); chk("R1 unused address reads zero", rv, 24'h000000);
        wr(A_MK, 24'h000000);
        rd(A_MK, rv); chk("R1 mask readback", rv, 24'h000000);
    endtask

    task automatic t_events();
        ev(24'h000080);
        chk("R5 masked event keeps irq high", {23'd0, irq_n_o}, 24'd1);
        rd(A_ST, rv); chk("R4 event sets bit while masked", rv & ~WDM, 24'h000081);
        wr(A_MK, 24'h000080);
        chk("R5 unmask drives irq low", {23'd0, irq_n_o}, 24'd0);
        ev(24'h000200);
        wr(A_ST, 24'h000080);
        rd(A_ST, rv); chk("R3 write-one clears, write-zero keeps", rv & ~WDM, 24'h000201);
        chk("R5 irq released after clear", {23'd0, irq_n_o}, 24'd1);
        wr(A_ST, 24'h000200);
        wr(A_MK, 24'h000020);
        ev(24'h000021);
        rd(A_ST, rv); chk("R4 event lines 0 and 5 ignored", rv, 24'h000001);
        chk("R4 no watchdog irq from event line", {23'd0, irq_n_o}, 24'd1);
        wr(A_MK, 24'h000000);
    endtask

    task automatic t_other_addr();
        ev(24'h001000);
        wr(A_MK, 24'h000400);
        wr(5'h10, 24'hFFFFFF);
        rd(A_ST, rv); chk("R10 status untouched", rv & ~WDM, 24'h001001);
        rd(A_MK, rv); chk("R10 mask untouched", rv, 24'h000400);
        wr(A_ST, 24'h001000);
        wr(A_MK, 24'h000000);
    endtask

    task automatic t_set_wins();
        addr_i = A_ST; wdata_i = 24'h000008; wr_i = 1'b1; evt_i = 24'h000008;
        @(negedge clk);
        wr_i = 1'b0; evt_i = '0; wdata_i = '0;
        rd(A_ST, rv); chk("R6 set beats clear", rv & ~WDM, 24'h000009);
        wr(A_ST, 24'h000008);
        rd(A_ST, rv); chk("R6 later clear works", rv & ~WDM, 24'h000001);
    endtask

    task automatic t_cmd_ok();
        wr(A_MK, 24'h000001);
        chk("R5 healthy bit0 no irq", {23'd0, irq_n_o}, 24'd1);
        cmd_err_i = 1'b1; @(negedge clk); cmd_err_i = 1'b0;
        chk("R7 error lowers bit0 and irq", {23'd0, irq_n_o}, 24'd0);
        wr(A_ST, 24'h000001);
        rd(A_ST, rv); chk("R7 write ignored by bit0", rv & ~WDM, 24'h000000);
        if_init_i = 1'b1; @(negedge clk); if_init_i = 1'b0;
        rd(A_ST, rv); chk("R7 init restores bit0", rv & ~WDM, 24'h000001);
        chk("R7 irq released", {23'd0, irq_n_o}, 24'd1);
        cmd_err_i = 1'b1; if_init_i = 1'b1; @(negedge clk);
        cmd_err_i = 1'b0; if_init_i = 1'b0;
        rd(A_ST, rv); chk("R7 error wins over init", rv & ~WDM, 24'h000000);
        if_init_i = 1'b1; @(negedge clk); if_init_i = 1'b0;
        wr(A_MK, 24'h000000);
    endtask

    task automatic t_watchdog();
        wr(A_MK, WDM);
        data_rd_i = 1'b1; @(negedge clk); data_rd_i = 1'b0;
        repeat (T - 2) @(negedge clk);
        data_rd_i = 1'b1; @(negedge clk); data_rd_i = 1'b0;
        repeat (T - 2) @(negedge clk);
        chk("R8 read restarts count", {23'd0, irq_n_o}, 24'd1);
        @(negedge clk);
        chk("R8 not yet expired", {23'd0, irq_n_o}, 24'd1);
        @(negedge clk);
        chk("R8 expires on time", {23'd0, irq_n_o}, 24'd0);
        wr(A_ST, WDM);
        chk("R9 clear without read refused", {23'd0, irq_n_o}, 24'd0);
        data_rd_i = 1'b1; @(negedge clk); data_rd_i = 1'b0;
        chk("R9 read alone keeps bit", {23'd0, irq_n_o}, 24'd0);
        wr(A_ST, WDM);
        rd(A_ST, rv); chk("R9 clear after read accepted", rv, 24'h000001);
        chk("R9 irq released", {23'd0, irq_n_o}, 24'd1);
        wr(A_MK, 24'h000000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mask_rw();
        t_events();
        t_other_addr();
        t_set_wins();
        t_cmd_ok();
        t_watchdog();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule